// File: doc/BRIEF.md
# ADC Result Router

This block takes each finished regular conversion result from an ADC core, formats it, and hands it to exactly one consumer. The 12-bit raw code is optionally reduced by a per-channel offset. That produces either a zero-extended or a sign-extended 16-bit word. The word is held in a result register that a DMA engine or software reads. In filter mode the word goes instead to a downstream digital filter over a valid/ready stream.

The block keeps an end-of-conversion flag (`eoc`) and a sticky overrun flag (`ovr`) for whichever path is active. There are three paths:
- **DMA path.** It runs either circular or one-shot. In circular mode every result raises a request. In one-shot mode requests stop after the DMA signals its final transfer, and resume only after a re-arm pulse.
- **Filter path.** It uses valid/ready back-pressure. `flt_valid` rises one cycle after a result arrives. It stays high with `flt_data` unchanged until a cycle in which `flt_ready` is high. The handshake consumes the word, and hardware clears `eoc`. A new result that arrives while the word is still waiting replaces it and sets `ovr`.
- **Software path.** It is used when neither DMA nor filter mode is selected.

Top module: `adc_result_router`

## Requirements
- R1: With `cfg_dma_en=1` and `cfg_dma_circ=1`, every result raises `dma_req` in the following cycle, whatever `dma_last` has signalled before.
- R2: With `cfg_dma_en=1` and `cfg_dma_circ=0`, a handshake (`dma_req` and `dma_ack` both high) with `dma_last=1` disarms requests. Later results still set `eoc` and update `res_word` but raise no `dma_req` until a one-cycle `dma_rearm` pulse.
- R3: `flt_valid` is raised only for results that arrive while `cfg_filt_en=1` and `cfg_dma_en=0`. A result under any other setting leaves `flt_valid` low.
- R4: Once raised, `flt_valid` stays high with `flt_data` stable until `flt_ready` is high. The cycle after that handshake, `eoc` is low unless a new result arrived.
- R5: With the channel's bit in `cfg_ofs_en` set, the word is (raw − offset) as a 13-bit two's-complement value sign-extended to 16 bits. The offset of channel n is `cfg_ofs_val[12n+11:12n]`. With offset 0x800, bit 11 is the sign and bits 15:12 copy it.
- R6: With the channel's `cfg_ofs_en` bit clear, the word is the raw code zero-extended to 16 bits.
- R7: With `cfg_left_align=1`, the word on `res_word` for the DMA and software paths is `{word[11:0], 4'b0000}`. On the filter path the setting is ignored and the word stays right-aligned.
- R8: A result that arrives while `eoc` is set and not consumed in the same cycle sets `ovr` and replaces the held word. `ovr` stays set until an `ovr_clr` pulse.
- R9: A result that arrives in the same cycle as the previous word is consumed does not set `ovr`. The new word is then held and delivered after the old one.
- R10: Each result sets `eoc` one cycle later. A DMA handshake, a filter handshake or a `dr_rd` pulse clears it.
- R11: After reset, `dma_req`, `flt_valid`, `eoc` and `ovr` are low and one-shot requests are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dma_en | input | 1 | Route results to the DMA request |
| cfg_dma_circ | input | 1 | 1: circular DMA, 0: one-shot |
| cfg_filt_en | input | 1 | Forward results to the filter stream (only when DMA is off) |
| cfg_left_align | input | 1 | Left-align `res_word` on DMA/software paths |
| cfg_ofs_en | input | 4 | Per-channel offset enable |
| cfg_ofs_val | input | 48 | Per-channel 12-bit offsets, channel n in bits 12n+11:12n |
| res_valid | input | 1 | One-cycle strobe: new conversion result |
| res_chan | input | 2 | Channel of the result |
| res_raw | input | 12 | Raw conversion code |
| dr_rd | input | 1 | Software read strobe, clears `eoc` |
| res_word | output | 16 | Held formatted result |
| eoc | output | 1 | End-of-conversion flag |
| ovr | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears `ovr` |
| dma_req | output | 1 | DMA request, held until acknowledged |
| dma_ack | input | 1 | DMA acknowledge |
| dma_last | input | 1 | Qualifies an acknowledge as the final transfer |
| dma_rearm | input | 1 | Re-arms one-shot requests |
| flt_valid | output | 1 | Filter stream valid |
| flt_ready | input | 1 | Filter stream ready |
| flt_data | output | 16 | Filter stream data, right-aligned signed word |

## Verification
The interesting collision is a new result landing in the same cycle that the consumer takes the previous word. This can happen as a filter handshake or a DMA acknowledge.

The bench holds `flt_ready` low until a word is waiting. It then raises `flt_ready` in the very cycle that it strobes the next result. It judges the outcome by three things:
- the scoreboard receives both words in order;
- `ovr` stays low;
- `flt_valid` remains high for the second word.

A separate case strobes the second result while `flt_ready` stays low. That case must set `ovr`, and only the newer word may reach the scoreboard.

// File: rtl/adc_route_pkg.sv
package adc_route_pkg;
  typedef enum logic [1:0] {
    PATH_SW  = 2'd0,
    PATH_DMA = 2'd1,
    PATH_FLT = 2'd2
  } route_path_e;

  function automatic route_path_e pick_path(input logic dma_en, input logic filt_en);
    if (dma_en)       return PATH_DMA;
    else if (filt_en) return PATH_FLT;
    else              return PATH_SW;
  endfunction
endpackage

// File: rtl/adc_word_fmt.sv
module adc_word_fmt #(
  parameter int RAW_W  = 12,
  parameter int WORD_W = 16,
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EXT_W = WORD_W - RAW_W - 1
) (
  input  logic [NUM_CH-1:0]       ofs_en_vec,
  input  logic [NUM_CH*RAW_W-1:0] ofs_val_vec,
  input  logic [CH_W-1:0]         chan,
  input  logic [RAW_W-1:0]        raw,
  input  logic                    left,
  output logic [WORD_W-1:0]       word_right,
  output logic [WORD_W-1:0]       word_shown
);
  logic [RAW_W-1:0] ofs_arr [NUM_CH];
  logic [RAW_W:0]   diff;
  logic [RAW_W-1:0] ofs_sel;
  logic             ofs_on;

  // unpack the flat per-channel offset bus
  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign ofs_arr[g] = ofs_val_vec[g*RAW_W +: RAW_W];
  end

  assign ofs_sel = ofs_arr[chan];
  assign ofs_on  = ofs_en_vec[chan];
  assign diff    = {1'b0, raw} - {1'b0, ofs_sel};

  always_comb begin
    if (ofs_on) word_right = {{EXT_W{diff[RAW_W]}}, diff};
    else        word_right = {{(WORD_W-RAW_W){1'b0}}, raw};
  end

  // left-aligned view drops the extension bits and pads on the right
  assign word_shown = left ? {word_right[RAW_W-1:0], {(WORD_W-RAW_W){1'b0}}} : word_right;
endmodule

// File: rtl/adc_dma_ctl.sv
module adc_dma_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic drop,
  input  logic circ,
  input  logic ack,
  input  logic last,
  input  logic rearm,
  output logic req
);
  logic armed;
  logic ack_fire;
  logic disarm;

  assign ack_fire = req & ack;
  assign disarm   = ack_fire & last & ~circ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      req   <= 1'b0;
    end else begin
      if (rearm)       armed <= 1'b1;
      else if (disarm) armed <= 1'b0;

      if (load)          req <= circ | (armed & ~disarm) | rearm;
      else if (drop)     req <= 1'b0;
      else if (ack_fire) req <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_flt_port.sv
module adc_flt_port (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic drop,
  input  logic ready,
  output logic valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              valid <= 1'b0;
    else if (load)           valid <= 1'b1;
    else if (drop)           valid <= 1'b0;
    else if (valid && ready) valid <= 1'b0;
  end
endmodule

// File: rtl/adc_flag_ctl.sv
module adc_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic new_res,
  input  logic consume,
  input  logic ovr_clr,
  output logic eoc,
  output logic ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (new_res)      eoc <= 1'b1;
      else if (consume) eoc <= 1'b0;

      if (new_res && eoc && !consume) ovr <= 1'b1;
      else if (ovr_clr)               ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_result_router.sv
module adc_result_router
  import adc_route_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int WORD_W = 16,
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_dma_en,
  input  logic                    cfg_dma_circ,
  input  logic                    cfg_filt_en,
  input  logic                    cfg_left_align,
  input  logic [NUM_CH-1:0]       cfg_ofs_en,
  input  logic [NUM_CH*RAW_W-1:0] cfg_ofs_val,
  input  logic                    res_valid,
  input  logic [CH_W-1:0]         res_chan,
  input  logic [RAW_W-1:0]        res_raw,
  input  logic                    dr_rd,
  output logic [WORD_W-1:0]       res_word,
  output logic                    eoc,
  output logic                    ovr,
  input  logic                    ovr_clr,
  output logic                    dma_req,
  input  logic                    dma_ack,
  input  logic                    dma_last,
  input  logic                    dma_rearm,
  output logic                    flt_valid,
  input  logic                    flt_ready,
  output logic [WORD_W-1:0]       flt_data
);
  route_path_e       path;
  logic [WORD_W-1:0] w_right;
  logic [WORD_W-1:0] w_shown;
  logic [WORD_W-1:0] word_q;
  logic              to_dma;
  logic              to_flt;
  logic              consume;

  assign path   = pick_path(cfg_dma_en, cfg_filt_en);
  assign to_dma = res_valid && (path == PATH_DMA);
  assign to_flt = res_valid && (path == PATH_FLT);

  adc_word_fmt #(.RAW_W(RAW_W), .WORD_W(WORD_W), .NUM_CH(NUM_CH)) fmt_i (
    .ofs_en_vec (cfg_ofs_en),
    .ofs_val_vec(cfg_ofs_val),
    .chan       (res_chan),
    .raw        (res_raw),
    .left       (cfg_left_align),
    .word_right (w_right),
    .word_shown (w_shown)
  );

  // filter path is always right aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (to_flt)    word_q <= w_right;
    else if (res_valid) word_q <= w_shown;
  end

  assign res_word = word_q;
  assign flt_data = word_q;

  adc_dma_ctl dma_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (to_dma),
    .drop (res_valid && !to_dma),
    .circ (cfg_dma_circ),
    .ack  (dma_ack),
    .last (dma_last),
    .rearm(dma_rearm),
    .req  (dma_req)
  );

  adc_flt_port flt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (to_flt),
    .drop (res_valid && !to_flt),
    .ready(flt_ready),
    .valid(flt_valid)
  );

  assign consume = (flt_valid && flt_ready) || (dma_req && dma_ack) || dr_rd;

  adc_flag_ctl flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .new_res(res_valid),
    .consume(consume),
    .ovr_clr(ovr_clr),
    .eoc    (eoc),
    .ovr    (ovr)
  );
endmodule

// File: rtl/adc_result_router_chk.sv
module adc_result_router_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              cfg_dma_en,
  input logic              cfg_dma_circ,
  input logic              cfg_filt_en,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              dr_rd,
  input logic              flt_valid,
  input logic              flt_ready,
  input logic [WORD_W-1:0] flt_data,
  input logic              eoc,
  input logic              ovr
);
  logic taken;
  assign taken = (flt_valid && flt_ready) || (dma_req && dma_ack) || dr_rd;

  assert_circ_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cfg_dma_en && cfg_dma_circ) |=> dma_req);

  assert_flt_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(cfg_filt_en && !cfg_dma_en)) |=> !flt_valid);

  assert_flt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_ready && !res_valid) |=> (flt_valid && $stable(flt_data)));

  assert_eoc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_ready && !res_valid) |=> !eoc);

  assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && eoc && !taken) |=> ovr);

  assert_no_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && eoc && taken && !ovr) |=> !ovr);
endmodule

bind adc_result_router adc_result_router_chk #(.WORD_W(WORD_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .res_valid   (res_valid),
  .cfg_dma_en  (cfg_dma_en),
  .cfg_dma_circ(cfg_dma_circ),
  .cfg_filt_en (cfg_filt_en),
  .dma_req     (dma_req),
  .dma_ack     (dma_ack),
  .dr_rd       (dr_rd),
  .flt_valid   (flt_valid),
  .flt_ready   (flt_ready),
  .flt_data    (flt_data),
  .eoc         (eoc),
  .ovr         (ovr)
);

// File: tb/adc_result_router_tb.sv
`timescale 1ns/1ps
module adc_result_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dma_en = 0, cfg_dma_circ = 0, cfg_filt_en = 0, cfg_left_align = 0;
  logic [3:0]  cfg_ofs_en;
  logic [47:0] cfg_ofs_val;
  logic        res_valid = 0;
  logic [1:0]  res_chan = 0;
  logic [11:0] res_raw = 0;
  logic        dr_rd = 0, ovr_clr = 0, dma_ack = 0, dma_last = 0, dma_rearm = 0, flt_ready = 0;
  logic [15:0] res_word, flt_data;
  logic        eoc, ovr, dma_req, flt_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  adc_result_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_dma_circ(cfg_dma_circ),
    .cfg_filt_en(cfg_filt_en), .cfg_left_align(cfg_left_align), .cfg_ofs_en(cfg_ofs_en),
    .cfg_ofs_val(cfg_ofs_val), .res_valid(res_valid), .res_chan(res_chan), .res_raw(res_raw),
    .dr_rd(dr_rd), .res_word(res_word), .eoc(eoc), .ovr(ovr), .ovr_clr(ovr_clr),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_last(dma_last), .dma_rearm(dma_rearm),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_data(flt_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected word from the requirements (R5, R6, R7)
  function automatic logic [15:0] exp_word(input int ch, input logic [11:0] raw);
    logic [15:0] w;
    logic [11:0] ofs;
    bit filt;
    ofs  = cfg_ofs_val[ch*12 +: 12];
    filt = cfg_filt_en && !cfg_dma_en;
    if (cfg_ofs_en[ch]) w = 16'(signed'({1'b0, raw}) - signed'({1'b0, ofs}));
    else                w = {4'h0, raw};
    if (cfg_left_align && !filt) w = {w[11:0], 4'h0};
    return w;
  endfunction

  // driver: one result strobe; tracked items go to the scoreboard
  task automatic push(input int ch, input logic [11:0] raw, input bit tracked,
                      input bit ovw, input string tag);
    @(posedge clk); #1;
    res_valid = 1; res_chan = 2'(ch); res_raw = raw;
    if (tracked) begin
      if (ovw && exp_q.size() > 0) begin
        exp_q[exp_q.size()-1] = exp_word(ch, raw);
        tag_q[tag_q.size()-1] = tag;
      end else begin
        exp_q.push_back(exp_word(ch, raw));
        tag_q.push_back(tag);
      end
    end
    @(posedge clk); #1;
    res_valid = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_dr_rd();
    @(posedge clk); #1; dr_rd = 1;
    @(posedge clk); #1; dr_rd = 0;
  endtask

  // monitor: pop and compare at every consumer handshake
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (flt_valid && flt_ready) begin
        if (exp_q.size() == 0) check("R4 unexpected filter word", flt_data, 16'hxxxx);
        else check(tag_q.pop_front(), flt_data, exp_q.pop_front());
      end
      if (dma_req && dma_ack) begin
        if (exp_q.size() == 0) check("R1 unexpected DMA word", res_word, 16'hxxxx);
        else check(tag_q.pop_front(), res_word, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg_ofs_en  = 4'b1011;
    cfg_ofs_val = {12'h800, 12'h000, 12'h100, 12'h800};
    wait_cyc(4);
    @(negedge clk);
    check("R11 dma_req", {15'd0, dma_req}, 16'd0);
    check("R11 flt_valid", {15'd0, flt_valid}, 16'd0);
    check("R11 eoc", {15'd0, eoc}, 16'd0);
    check("R11 ovr", {15'd0, ovr}, 16'd0);
    @(posedge clk); #1; rst_n = 1;

    // filter path, signed and unsigned formats
    cfg_filt_en = 1; flt_ready = 1;
    push(0, 12'h000, 1, 0, "R5 min code");
    push(0, 12'hFFF, 1, 0, "R5 max code");
    push(0, 12'h800, 1, 0, "R5 midscale");
    push(1, 12'h050, 1, 0, "R5 channel1 offset");
    push(2, 12'hABC, 1, 0, "R6 offset off");
    cfg_left_align = 1;
    push(0, 12'h123, 1, 0, "R7 filter ignores left align");
    cfg_left_align = 0;
    wait_cyc(2);
    @(negedge clk); check("R4 eoc cleared after handshake", {15'd0, eoc}, 16'd0);

    // back-pressure and overrun
    flt_ready = 0;
    push(3, 12'h900, 1, 0, "R8 overwritten");
    wait_cyc(3);
    @(negedge clk);
    check("R4 valid held", {15'd0, flt_valid}, 16'd1);
    check("R4 data held", flt_data, 16'h0100);
    check("R10 eoc set", {15'd0, eoc}, 16'd1);
    push(3, 12'h7FF, 1, 1, "R8 newer word");
    @(negedge clk);
    check("R8 ovr set", {15'd0, ovr}, 16'd1);
    check("R8 data replaced", flt_data, 16'hFFFF);
    @(posedge clk); #1; flt_ready = 1;
    wait_cyc(2);
    @(posedge clk); #1; ovr_clr = 1;
    @(posedge clk); #1; ovr_clr = 0;
    @(negedge clk); check("R8 ovr cleared", {15'd0, ovr}, 16'd0);

    // consume and new result in the same cycle
    flt_ready = 0;
    push(0, 12'h801, 1, 0, "R9 first word");
    wait_cyc(1);
    @(posedge clk); #1;
    flt_ready = 1; res_valid = 1; res_chan = 0; res_raw = 12'h7FE;
    exp_q.push_back(exp_word(0, 12'h7FE)); tag_q.push_back("R9 second word");
    @(posedge clk); #1; res_valid = 0;
    @(negedge clk);
    check("R9 no overrun", {15'd0, ovr}, 16'd0);
    check("R9 second word valid", {15'd0, flt_valid}, 16'd1);
    wait_cyc(2);

    // DMA enabled with filter enabled: filter stays idle
    cfg_dma_en = 1; cfg_dma_circ = 1; cfg_left_align = 1;
    push(2, 12'h345, 1, 0, "R7 left aligned DMA word");
    @(negedge clk);
    check("R3 filter idle with DMA on", {15'd0, flt_valid}, 16'd0);
    check("R1 request raised", {15'd0, dma_req}, 16'd1);
    @(posedge clk); #1; dma_ack = 1;
    wait_cyc(1);
    cfg_left_align = 0;

    // circular mode keeps requesting past the last transfer
    dma_last = 1;
    for (int k = 0; k < 3; k++) begin
      push(1, 12'h200 + 12'(k), 1, 0, "R1 circular word");
      @(negedge clk); check("R1 request after last", {15'd0, dma_req}, 16'd1);
    end
    wait_cyc(2);

    // one-shot: last transfer disarms, rearm restores
    cfg_dma_circ = 0;
    push(0, 12'hC00, 1, 0, "R2 final one-shot word");
    wait_cyc(2);
    dma_last = 0;
    push(0, 12'hA00, 0, 0, "");
    @(negedge clk);
    check("R2 no request when disarmed", {15'd0, dma_req}, 16'd0);
    check("R2 eoc set when disarmed", {15'd0, eoc}, 16'd1);
    check("R2 word updated", res_word, 16'h0200);
    pulse_dr_rd();
    @(negedge clk); check("R10 dr_rd clears eoc", {15'd0, eoc}, 16'd0);
    @(posedge clk); #1; dma_rearm = 1;
    @(posedge clk); #1; dma_rearm = 0;
    push(0, 12'h900, 1, 0, "R2 rearmed word");
    @(negedge clk); check("R2 request after rearm", {15'd0, dma_req}, 16'd1);
    wait_cyc(2);

    // software path
    cfg_dma_en = 0; cfg_filt_en = 0; cfg_left_align = 1;
    push(2, 12'h0F0, 0, 0, "");
    @(negedge clk);
    check("R3 filter idle in software mode", {15'd0, flt_valid}, 16'd0);
    check("R10 no DMA request in software mode", {15'd0, dma_req}, 16'd0);
    check("R10 eoc set", {15'd0, eoc}, 16'd1);
    check("R7 left aligned software word", res_word, 16'h0F00);
    pulse_dr_rd();
    @(negedge clk); check("R10 eoc cleared by read", {15'd0, eoc}, 16'd0);

    check("R1 scoreboard drained", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule